// File: doc/BRIEF.md
# Queued-Command I2C Master Engine

This block is the sequencing core of an I2C master. Software, or a host state machine, describes each bus transaction as a short list of command words. Each word carries a byte count and a set of flags: open with a START, close with a STOP, act as master, transmit or receive, NAK the final received byte, and keep the clock held after the last byte. Transmit payload is pushed into a 32-bit write queue, four bytes per word with the first byte in the low lane. Received bytes come back in the same packing through a 32-bit read queue.

While the run input is high, the engine takes commands in order and breaks every byte into single bit-level operations. It hands these to an external SCL timing generator through a request/done handshake. The generator returns the sampled data line and an arbitration-loss indication. A write is one transmit command whose first byte is the 7-bit chip address shifted up one place with a 0 direction bit. A read is a one-byte transmit command with START and clock-hold set, carrying the address with a 1 direction bit, followed by a receive command with NAK-on-last and STOP set. A repeated start comes from ending a transmit command without STOP and starting the next command with START.

Sticky flags report command-list completion, a missing acknowledge, a transmit underrun, a lost arbitration, and two bus-monitor events. Each flag has its own clear strobe.

Top module: `i2cq_master`

## Requirements
- R1: Command word fields: bits [CNT_W-1:0] byte count, bit CNT_W START, CNT_W+1 STOP, CNT_W+2 master, CNT_W+3 transmit, CNT_W+4 NAK-on-last, CNT_W+5 clock-hold. Commands run in push order. None begins while `q_run` is low.
- R2: Bit operations use `bit_op` codes 0 = START, 1 = STOP, 2 = write bit `bit_wdat`, 3 = read bit. Each is a one-cycle `bit_req` pulse, and the next is issued only after `bit_done`.
- R3: A transmit command sends `count` bytes MSB first. Bytes come from write-queue words lane 0 ([7:0]) upward. A word is popped after its lane 3 byte or after the command's last byte, so every command starts on a fresh word.
- R4: After each transmitted byte, one read-bit operation samples the acknowledge. A 0 lets the command continue.
- R5: A 1 in that acknowledge slot sets flag 1 (no acknowledge) and issues STOP. The command's remaining bytes are discarded from the write queue, and the next command then runs normally.
- R6: A receive command performs 8 read bits per byte, MSB first, then writes an acknowledge bit. That bit is 0, except 1 for the last byte when NAK-on-last is set. Bytes pack into read-queue words from lane 0, and a word is pushed after 4 bytes or at the command's end.
- R7: START is issued only when the START flag is set, and STOP only when the STOP flag is set. A transmit command without STOP followed by one with START yields a repeated start.
- R8: After a command with clock-hold set and STOP clear, `scl_hold` is 1 until the next command is taken. It is 0 whenever a bit operation is requested.
- R9: A command with the master flag clear is consumed with no bit operations and no write-queue access.
- R10: A transmit byte needed while the write queue holds no word sets flag 2 (early termination) and issues STOP, ending the command.
- R11: `bit_lost` with `bit_done` sets flag 3 (arbitration loss). No further bit operation, STOP included, is issued for that command, and its unsent write bytes are discarded.
- R12: Flag 0 (complete) is set when a command finishes and the command queue is empty.
- R13: Flags are sticky. `flag_clr[i]` clears flag i alone, and a set in the same cycle wins. `mon_stop` sets flag 4 and `mon_sevt` sets flag 5.
- R14: `wq_empty` and `rq_empty` are 1 when the write or read queue holds no word. `rq_data` shows the oldest read word, and `rq_pop` removes it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| q_run | input | 1 | Allow command execution |
| cmd_push | input | 1 | Push command word |
| cmd_data | input | CNT_W+6 | Command word |
| wq_push | input | 1 | Push transmit data word |
| wq_data | input | 32 | Transmit data word |
| wq_empty | output | 1 | Write queue empty |
| rq_pop | input | 1 | Pop read data word |
| rq_data | output | 32 | Oldest read data word |
| rq_empty | output | 1 | Read queue empty |
| flags | output | 6 | Sticky flags: 0 complete, 1 no-ack, 2 early term, 3 arb loss, 4 slave stop, 5 slave event |
| flag_clr | input | 6 | Per-flag clear strobes |
| mon_stop | input | 1 | Bus monitor saw a STOP as slave |
| mon_sevt | input | 1 | Bus monitor slave event |
| bit_req | output | 1 | Bit operation request pulse |
| bit_op | output | 2 | Bit operation code |
| bit_wdat | output | 1 | Data bit for a write-bit operation |
| bit_done | input | 1 | Timing generator finished the operation |
| bit_rdat | input | 1 | Sampled data line for read-bit operations |
| bit_lost | input | 1 | Arbitration lost during the operation |
| scl_hold | output | 1 | Hold SCL low between commands |

## Verification
Two pairs of events can fall in the same cycle. A monitor event and the software clear of that same flag can coincide. The bench drives `mon_stop` together with `flag_clr[4]` on one edge and expects the flag to be set afterwards. It then clears the flag alone and expects only that bit to drop. The other pair is a missing acknowledge and the end of a partially sent write word: the acknowledge fails mid-word, and the bench judges the outcome by the exact operation sequence of the following command, which must begin on a fresh word.

// File: rtl/i2cq_pkg.sv
package i2cq_pkg;
  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_STOP  = 2'd1,
    OP_WRBIT = 2'd2,
    OP_RDBIT = 2'd3
  } bitop_e;

  localparam int NFLAGS   = 6;
  localparam int FL_DONE  = 0;
  localparam int FL_NAK   = 1;
  localparam int FL_EARLY = 2;
  localparam int FL_ARB   = 3;
  localparam int FL_SSTOP = 4;
  localparam int FL_SEVT  = 5;
endpackage

// File: rtl/i2cq_fifo.sv
module i2cq_fifo #(
  parameter int W  = 32,
  parameter int AW = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  output logic         full,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] mem [DEPTH];
  logic [AW:0]  wp, rp;
  logic         do_push, do_pop;

  assign empty   = (wp == rp);
  assign full    = (wp[AW] != rp[AW]) && (wp[AW-1:0] == rp[AW-1:0]);
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp[AW-1:0]];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp[AW-1:0]] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp <= '0;
      rp <= '0;
    end else begin
      if (do_push) wp <= wp + 1'b1;
      if (do_pop)  rp <= rp + 1'b1;
    end
  end

  AST_Q_FULL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (full && !pop) |=> full); // R14
  AST_Q_EMPTY_HOLD: assert property (@(posedge clk) disable iff (rst)
    (empty && !push) |=> empty); // R14
endmodule

// File: rtl/i2cq_flags.sv
module i2cq_flags
  import i2cq_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [NFLAGS-1:0] set,
  input  logic [NFLAGS-1:0] clr,
  output logic [NFLAGS-1:0] flags
);
  for (genvar i = 0; i < NFLAGS; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (rst)         flags[i] <= 1'b0;
      else if (set[i]) flags[i] <= 1'b1;
      else if (clr[i]) flags[i] <= 1'b0;
    end

    AST_FLAG_SET_WINS: assert property (@(posedge clk) disable iff (rst)
      set[i] |=> flags[i]); // R13
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
      (flags[i] && !clr[i]) |=> flags[i]); // R13
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
      (clr[i] && !set[i]) |=> !flags[i]); // R13
  end
endmodule

// File: rtl/i2cq_engine.sv
module i2cq_engine
  import i2cq_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             q_run,
  input  logic             cmd_empty,
  input  logic [CNT_W+5:0] cmd_word,
  output logic             cmd_pop,
  input  logic             wq_empty,
  input  logic [31:0]      wq_word,
  output logic             wq_pop,
  input  logic             rq_full,
  output logic             rq_push,
  output logic [31:0]      rq_word,
  output logic             bit_req,
  output logic [1:0]       bit_op,
  output logic             bit_wdat,
  input  logic             bit_done,
  input  logic             bit_rdat,
  input  logic             bit_lost,
  output logic             scl_hold,
  output logic             ev_done,
  output logic             ev_nak,
  output logic             ev_early,
  output logic             ev_arb
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  typedef enum logic [3:0] {
    ST_IDLE, ST_BEGIN, ST_LOAD, ST_BITS, ST_TXACK, ST_RXACK,
    ST_END, ST_ABORT, ST_DRAIN, ST_DGAP, ST_FIN
  } state_e;

  state_e           st;
  logic             wt;
  logic [CNT_W-1:0] cnt;
  logic             f_start, f_stop, f_master, f_tx, f_nak, f_ret;
  logic [7:0]       sh;
  logic [2:0]       bitn;
  logic [1:0]       txl, rxl;
  logic [31:0]      rxw, rx_merged;
  logic [7:0]       tx_byte;

  assign tx_byte = wq_word[{txl, 3'b000} +: 8];

  always_comb begin
    rx_merged = rxw;
    rx_merged[{rxl, 3'b000} +: 8] = sh;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE;  wt <= 1'b0;  cnt <= '0;
      f_start <= 1'b0; f_stop <= 1'b0; f_master <= 1'b0;
      f_tx <= 1'b0;    f_nak <= 1'b0;  f_ret <= 1'b0;
      sh <= '0; bitn <= '0; txl <= '0; rxl <= '0; rxw <= '0;
      cmd_pop <= 1'b0; wq_pop <= 1'b0; rq_push <= 1'b0; rq_word <= '0;
      bit_req <= 1'b0; bit_op <= OP_START; bit_wdat <= 1'b0;
      scl_hold <= 1'b0;
      ev_done <= 1'b0; ev_nak <= 1'b0; ev_early <= 1'b0; ev_arb <= 1'b0;
    end else begin
      bit_req  <= 1'b0;
      cmd_pop  <= 1'b0;
      wq_pop   <= 1'b0;
      rq_push  <= 1'b0;
      ev_done  <= 1'b0;
      ev_nak   <= 1'b0;
      ev_early <= 1'b0;
      ev_arb   <= 1'b0;
      if (wt) begin
        if (bit_done) begin
          wt <= 1'b0;
          if (bit_lost) begin
            ev_arb <= 1'b1;
            st     <= ST_DRAIN;
          end else begin
            case (st)
              ST_BEGIN: st <= ST_LOAD;
              ST_BITS: begin
                sh <= f_tx ? {sh[6:0], 1'b0} : {sh[6:0], bit_rdat};
                if (bitn == 3'd0) st <= f_tx ? ST_TXACK : ST_RXACK;
                else              bitn <= bitn - 3'd1;
              end
              ST_TXACK: begin
                if (bit_rdat) begin
                  ev_nak <= 1'b1;
                  st     <= ST_ABORT;
                end else begin
                  st <= ST_LOAD;
                end
              end
              ST_RXACK: begin
                if (rxl == 2'd3 || cnt == '0) begin
                  rq_push <= 1'b1;
                  rq_word <= rx_merged;
                  rxw     <= '0;
                  rxl     <= 2'd0;
                end else begin
                  rxw <= rx_merged;
                  rxl <= rxl + 2'd1;
                end
                st <= ST_LOAD;
              end
              ST_ABORT: st <= ST_DRAIN;
              default:  st <= ST_FIN;
            endcase
          end
        end
      end else begin
        case (st)
          ST_IDLE: begin
            if (q_run && !cmd_empty) begin
              cmd_pop  <= 1'b1;
              cnt      <= cmd_word[CNT_W-1:0];
              f_start  <= cmd_word[CNT_W];
              f_stop   <= cmd_word[CNT_W+1];
              f_master <= cmd_word[CNT_W+2];
              f_tx     <= cmd_word[CNT_W+3];
              f_nak    <= cmd_word[CNT_W+4];
              f_ret    <= cmd_word[CNT_W+5];
              scl_hold <= 1'b0;
              txl      <= 2'd0;
              rxl      <= 2'd0;
              rxw      <= '0;
              st       <= ST_BEGIN;
            end
          end
          ST_BEGIN: begin
            if (!f_master) begin
              st <= ST_FIN;
            end else if (f_start) begin
              bit_req <= 1'b1; bit_op <= OP_START; bit_wdat <= 1'b0; wt <= 1'b1;
            end else begin
              st <= ST_LOAD;
            end
          end
          ST_LOAD: begin
            if (cnt == '0) begin
              st <= ST_END;
            end else if (f_tx) begin
              if (txl == 2'd0 && wq_empty) begin
                ev_early <= 1'b1;
                st       <= ST_ABORT;
              end else begin
                sh  <= tx_byte;
                cnt <= cnt - 1'b1;
                if (txl == 2'd3 || cnt == CNT_ONE) begin
                  wq_pop <= 1'b1;
                  txl    <= 2'd0;
                end else begin
                  txl <= txl + 2'd1;
                end
                bitn <= 3'd7;
                st   <= ST_BITS;
              end
            end else if (!(rq_full || rq_push)) begin
              cnt  <= cnt - 1'b1;
              bitn <= 3'd7;
              st   <= ST_BITS;
            end
          end
          ST_BITS: begin
            bit_req  <= 1'b1;
            bit_op   <= f_tx ? OP_WRBIT : OP_RDBIT;
            bit_wdat <= f_tx ? sh[7] : 1'b1;
            wt       <= 1'b1;
          end
          ST_TXACK: begin
            bit_req <= 1'b1; bit_op <= OP_RDBIT; bit_wdat <= 1'b1; wt <= 1'b1;
          end
          ST_RXACK: begin
            bit_req  <= 1'b1;
            bit_op   <= OP_WRBIT;
            bit_wdat <= f_nak && (cnt == '0);
            wt       <= 1'b1;
          end
          ST_END: begin
            if (f_stop) begin
              bit_req <= 1'b1; bit_op <= OP_STOP; bit_wdat <= 1'b0; wt <= 1'b1;
            end else begin
              scl_hold <= f_ret;
              st       <= ST_FIN;
            end
          end
          ST_ABORT: begin
            bit_req <= 1'b1; bit_op <= OP_STOP; bit_wdat <= 1'b0; wt <= 1'b1;
          end
          ST_DRAIN: begin
            if (!f_tx || cnt == '0 || (txl == 2'd0 && wq_empty)) begin
              st <= ST_FIN;
            end else begin
              cnt <= cnt - 1'b1;
              if (txl == 2'd3 || cnt == CNT_ONE) begin
                wq_pop <= 1'b1;
                txl    <= 2'd0;
              end else begin
                txl <= txl + 2'd1;
              end
              st <= ST_DGAP;
            end
          end
          ST_DGAP: st <= ST_DRAIN;
          ST_FIN: begin
            ev_done <= cmd_empty;
            st      <= ST_IDLE;
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (rst)
    bit_req |=> !bit_req); // R2
  AST_HOLD_QUIET: assert property (@(posedge clk) disable iff (rst)
    scl_hold |-> !bit_req); // R8
  AST_RUN_GATE: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && !q_run) |=> (st == ST_IDLE)); // R1
  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ev_nak, ev_early, ev_arb})); // R5
endmodule

// File: rtl/i2cq_master.sv
module i2cq_master
  import i2cq_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int CQ_AW = 2,
  parameter int DQ_AW = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             q_run,
  input  logic             cmd_push,
  input  logic [CNT_W+5:0] cmd_data,
  input  logic             wq_push,
  input  logic [31:0]      wq_data,
  output logic             wq_empty,
  input  logic             rq_pop,
  output logic [31:0]      rq_data,
  output logic             rq_empty,
  output logic [5:0]       flags,
  input  logic [5:0]       flag_clr,
  input  logic             mon_stop,
  input  logic             mon_sevt,
  output logic             bit_req,
  output logic [1:0]       bit_op,
  output logic             bit_wdat,
  input  logic             bit_done,
  input  logic             bit_rdat,
  input  logic             bit_lost,
  output logic             scl_hold
);
  localparam int CMD_W = CNT_W + 6;

  logic             cmd_full, cmd_empty, cmd_pop;
  logic [CMD_W-1:0] cmd_word;
  logic             wq_full, wq_pop;
  logic [31:0]      wq_word;
  logic             rq_full, rq_push;
  logic [31:0]      rq_word;
  logic             ev_done, ev_nak, ev_early, ev_arb;
  logic [NFLAGS-1:0] fl_set;

  i2cq_fifo #(.W(CMD_W), .AW(CQ_AW)) u_cmdq (
    .clk(clk), .rst(rst), .push(cmd_push && !cmd_full), .din(cmd_data),
    .full(cmd_full), .pop(cmd_pop), .dout(cmd_word), .empty(cmd_empty));

  i2cq_fifo #(.W(32), .AW(DQ_AW)) u_wrq (
    .clk(clk), .rst(rst), .push(wq_push && !wq_full), .din(wq_data),
    .full(wq_full), .pop(wq_pop), .dout(wq_word), .empty(wq_empty));

  i2cq_fifo #(.W(32), .AW(DQ_AW)) u_rdq (
    .clk(clk), .rst(rst), .push(rq_push), .din(rq_word),
    .full(rq_full), .pop(rq_pop), .dout(rq_data), .empty(rq_empty));

  i2cq_engine #(.CNT_W(CNT_W)) u_eng (
    .clk(clk), .rst(rst), .q_run(q_run),
    .cmd_empty(cmd_empty), .cmd_word(cmd_word), .cmd_pop(cmd_pop),
    .wq_empty(wq_empty), .wq_word(wq_word), .wq_pop(wq_pop),
    .rq_full(rq_full), .rq_push(rq_push), .rq_word(rq_word),
    .bit_req(bit_req), .bit_op(bit_op), .bit_wdat(bit_wdat),
    .bit_done(bit_done), .bit_rdat(bit_rdat), .bit_lost(bit_lost),
    .scl_hold(scl_hold),
    .ev_done(ev_done), .ev_nak(ev_nak), .ev_early(ev_early), .ev_arb(ev_arb));

  always_comb begin
    fl_set = '0;
    fl_set[FL_DONE]  = ev_done;
    fl_set[FL_NAK]   = ev_nak;
    fl_set[FL_EARLY] = ev_early;
    fl_set[FL_ARB]   = ev_arb;
    fl_set[FL_SSTOP] = mon_stop;
    fl_set[FL_SEVT]  = mon_sevt;
  end

  i2cq_flags u_flags (
    .clk(clk), .rst(rst), .set(fl_set), .clr(flag_clr), .flags(flags));
endmodule

// File: tb/i2cq_master_test.sv
module i2cq_master_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        q_run = 1'b1;
  logic        cmd_push = 1'b0;
  logic [13:0] cmd_data = '0;
  logic        wq_push = 1'b0;
  logic [31:0] wq_data = '0;
  logic        wq_empty;
  logic        rq_pop = 1'b0;
  logic [31:0] rq_data;
  logic        rq_empty;
  logic [5:0]  flags;
  logic [5:0]  flag_clr = '0;
  logic        mon_stop = 1'b0;
  logic        mon_sevt = 1'b0;
  logic        bit_req;
  logic [1:0]  bit_op;
  logic        bit_wdat;
  logic        bit_done = 1'b0;
  logic        bit_rdat = 1'b1;
  logic        bit_lost = 1'b0;
  logic        scl_hold;

  always #4 clk = ~clk;

  i2cq_master uut (
    .clk(clk), .rst(rst), .q_run(q_run), .cmd_push(cmd_push), .cmd_data(cmd_data),
    .wq_push(wq_push), .wq_data(wq_data), .wq_empty(wq_empty),
    .rq_pop(rq_pop), .rq_data(rq_data), .rq_empty(rq_empty),
    .flags(flags), .flag_clr(flag_clr), .mon_stop(mon_stop), .mon_sevt(mon_sevt),
    .bit_req(bit_req), .bit_op(bit_op), .bit_wdat(bit_wdat), .bit_done(bit_done),
    .bit_rdat(bit_rdat), .bit_lost(bit_lost), .scl_hold(scl_hold));

  int checks = 0;
  int errors = 0;
  logic [1:0] exp_op [0:1023];
  logic       exp_b  [0:1023];
  logic [1:0] got_op [0:1023];
  logic       got_b  [0:1023];
  logic       resp   [0:1023];
  int exp_n = 0, got_n = 0, resp_n = 0, resp_i = 0, lose_at = -1;
  logic [7:0] bytes [0:63];

  function automatic logic [13:0] mk_cmd(input int cnt, input bit st, input bit sp,
                                         input bit ms, input bit tx, input bit nk, input bit rt);
    return {rt, nk, tx, ms, sp, st, 8'(cnt)};
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic e_op(input logic [1:0] op, input logic b);
    exp_op[exp_n] = op; exp_b[exp_n] = b; exp_n++;
    if (op == 2'd3) begin resp[resp_n] = b; resp_n++; end
  endtask

  task automatic e_tx(input logic [7:0] b, input logic nak);
    for (int k = 7; k >= 0; k--) e_op(2'd2, b[k]);
    e_op(2'd3, nak);
  endtask

  task automatic e_rx(input logic [7:0] b, input logic ackb);
    for (int k = 7; k >= 0; k--) e_op(2'd3, b[k]);
    e_op(2'd2, ackb);
  endtask

  // timing generator model
  initial begin
    int idx;
    logic [1:0] op;
    forever begin
      @(negedge clk);
      if (bit_req) begin
        op = bit_op;
        idx = got_n;
        got_op[got_n] = bit_op;
        got_b[got_n] = bit_wdat;
        got_n++;
        @(negedge clk);
        @(negedge clk);
        bit_rdat = 1'b1;
        if (op == 2'd3 && resp_i < resp_n) begin
          bit_rdat = resp[resp_i];
          resp_i++;
        end
        bit_lost = (idx == lose_at);
        bit_done = 1'b1;
        @(negedge clk);
        bit_done = 1'b0;
        bit_lost = 1'b0;
      end
    end
  end

  task automatic push_cmd(input logic [13:0] w);
    @(negedge clk); cmd_push = 1'b1; cmd_data = w;
    @(negedge clk); cmd_push = 1'b0;
  endtask

  task automatic push_wq(input logic [31:0] w);
    @(negedge clk); wq_push = 1'b1; wq_data = w;
    @(negedge clk); wq_push = 1'b0;
  endtask

  task automatic push_bytes(input int n);
    for (int w = 0; w < (n + 3) / 4; w++) begin
      logic [31:0] v;
      v = '0;
      for (int k = 0; k < 4; k++)
        if (w * 4 + k < n) v[k*8 +: 8] = bytes[w*4 + k];
      push_wq(v);
    end
  endtask

  task automatic new_test();
    repeat (4) @(negedge clk);
    flag_clr = 6'h3f;
    @(negedge clk);
    flag_clr = '0;
    exp_n = 0; got_n = 0; resp_n = 0; resp_i = 0; lose_at = -1;
  endtask

  task automatic wait_done(input string req);
    int t;
    t = 0;
    while (!flags[0] && t < 20000) begin @(negedge clk); t++; end
    chk(flags[0], "R12", {req, " completion flag"}, flags, 1);
    repeat (8) @(negedge clk);
  endtask

  task automatic check_seq(input string req);
    int bad;
    bad = -1;
    chk(got_n == exp_n, req, "operation count", got_n, exp_n);
    for (int i = 0; i < exp_n && i < got_n; i++)
      if (bad < 0 && (got_op[i] != exp_op[i] ||
                      (exp_op[i] == 2'd2 && got_b[i] != exp_b[i]))) bad = i;
    if (bad >= 0)
      chk(1'b0, req, $sformatf("operation %0d op/bit", bad),
          {got_op[bad], got_b[bad]}, {exp_op[bad], exp_b[bad]});
    else
      chk(1'b1, req, "sequence", 0, 0);
  endtask

  bit finished = 0;

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL R2 watchdog expired actual=%0d expected=%0d", got_n, exp_n);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // reset state (R14, R13)
    chk(flags == 6'h00, "R13", "flags after reset", flags, 0);
    chk(wq_empty && rq_empty, "R14", "queues empty after reset", {wq_empty, rq_empty}, 3);
    chk(!bit_req && !scl_hold, "R8", "idle outputs after reset", {bit_req, scl_hold}, 0);

    // R3 R4 R7: write sweep across word boundaries
    for (int n = 1; n <= 9; n++) begin
      new_test();
      bytes[0] = 8'hA0;
      for (int k = 1; k < n; k++) bytes[k] = 8'((n * 37 + k * 11) & 255);
      push_bytes(n);
      push_cmd(mk_cmd(n, 1, 1, 1, 1, 0, 0));
      e_op(2'd0, 0);
      for (int k = 0; k < n; k++) e_tx(bytes[k], 0);
      e_op(2'd1, 0);
      wait_done("R3");
      check_seq("R3");
      chk(wq_empty, "R3", "write queue drained", wq_empty, 1);
      chk(flags == 6'h01, "R4", "flags after acked write", flags, 1);
    end

    // R6: read sweep with address phase and NAK on last
    for (int m = 1; m <= 9; m++) begin
      logic [7:0] rb [0:15];
      new_test();
      for (int k = 0; k < m; k++) rb[k] = 8'((m * 53 + k * 29 + 7) & 255);
      push_wq(32'h0000_00A1);
      push_cmd(mk_cmd(1, 1, 0, 1, 1, 0, 1));
      push_cmd(mk_cmd(m, 0, 1, 1, 0, 1, 0));
      e_op(2'd0, 0);
      e_tx(8'hA1, 0);
      for (int k = 0; k < m; k++) e_rx(rb[k], (k == m - 1));
      e_op(2'd1, 0);
      wait_done("R6");
      check_seq("R6");
      for (int w = 0; w < (m + 3) / 4; w++) begin
        logic [31:0] ev;
        ev = '0;
        for (int k = 0; k < 4; k++) if (w * 4 + k < m) ev[k*8 +: 8] = rb[w*4 + k];
        chk(!rq_empty && rq_data == ev, "R6", $sformatf("read word %0d", w), rq_data, ev);
        rq_pop = 1'b1; @(negedge clk); rq_pop = 1'b0; @(negedge clk);
      end
      chk(rq_empty, "R14", "read queue empty after pops", rq_empty, 1);
      chk(!scl_hold, "R8", "hold released after stop", scl_hold, 0);
    end

    // R8: clock hold between commands
    new_test();
    push_wq(32'h0000_00A1);
    push_cmd(mk_cmd(1, 1, 0, 1, 1, 0, 1));
    e_op(2'd0, 0);
    e_tx(8'hA1, 0);
    wait_done("R8");
    chk(scl_hold, "R8", "hold after retain command", scl_hold, 1);
    flag_clr = 6'h01; @(negedge clk); flag_clr = '0;
    push_cmd(mk_cmd(1, 0, 1, 1, 0, 1, 0));
    e_rx(8'h3C, 1);
    e_op(2'd1, 0);
    wait_done("R8");
    check_seq("R8");
    chk(!scl_hold, "R8", "hold cleared by next command", scl_hold, 0);
    chk(rq_data == 32'h0000_003C, "R6", "single byte read word", rq_data, 32'h3C);
    rq_pop = 1'b1; @(negedge clk); rq_pop = 1'b0;

    // R5: NAK mid word, next command starts on a fresh word
    new_test();
    push_wq(32'h3322_11A0);
    push_wq(32'h0000_5544);
    push_wq(32'h0000_66A0);
    push_cmd(mk_cmd(6, 1, 1, 1, 1, 0, 0));
    push_cmd(mk_cmd(2, 1, 1, 1, 1, 0, 0));
    e_op(2'd0, 0); e_tx(8'hA0, 0); e_tx(8'h11, 0); e_tx(8'h22, 1); e_op(2'd1, 0);
    e_op(2'd0, 0); e_tx(8'hA0, 0); e_tx(8'h66, 0); e_op(2'd1, 0);
    wait_done("R5");
    check_seq("R5");
    chk(wq_empty, "R5", "discarded bytes removed", wq_empty, 1);
    chk(flags == 6'h03, "R5", "no-ack flag", flags, 3);

    // R7: repeated start
    new_test();
    push_wq(32'h0000_5AA0);
    push_wq(32'h0000_00A1);
    push_cmd(mk_cmd(2, 1, 0, 1, 1, 0, 0));
    push_cmd(mk_cmd(1, 1, 1, 1, 1, 0, 0));
    e_op(2'd0, 0); e_tx(8'hA0, 0); e_tx(8'h5A, 0);
    e_op(2'd0, 0); e_tx(8'hA1, 0); e_op(2'd1, 0);
    wait_done("R7");
    check_seq("R7");

    // R9: master flag clear
    new_test();
    push_cmd(mk_cmd(3, 1, 1, 0, 1, 0, 0));
    wait_done("R9");
    chk(got_n == 0, "R9", "no bus activity", got_n, 0);
    chk(flags == 6'h01, "R9", "only completion flag", flags, 1);

    // R10: transmit underrun
    new_test();
    push_cmd(mk_cmd(3, 1, 1, 1, 1, 0, 0));
    e_op(2'd0, 0); e_op(2'd1, 0);
    wait_done("R10");
    check_seq("R10");
    chk(flags == 6'h05, "R10", "early termination flag", flags, 5);

    // R11: arbitration loss in second byte
    new_test();
    push_wq(32'h3322_11A0);
    push_wq(32'h0000_0044);
    push_cmd(mk_cmd(5, 1, 1, 1, 1, 0, 0));
    e_op(2'd0, 0); e_tx(8'hA0, 0); e_tx(8'h11, 0);
    lose_at = 12;
    exp_n = 13;
    wait_done("R11");
    check_seq("R11");
    chk(wq_empty, "R11", "unsent bytes discarded", wq_empty, 1);
    chk(flags == 6'h09, "R11", "arbitration flag", flags, 9);

    // R1: run gating
    new_test();
    q_run = 1'b0;
    push_wq(32'h0000_00A0);
    push_cmd(mk_cmd(1, 1, 1, 1, 1, 0, 0));
    repeat (30) @(negedge clk);
    chk(got_n == 0, "R1", "no operation while run low", got_n, 0);
    chk(!wq_empty, "R14", "write queue shows data", wq_empty, 0);
    q_run = 1'b1;
    e_op(2'd0, 0); e_tx(8'hA0, 0); e_op(2'd1, 0);
    wait_done("R1");
    check_seq("R1");

    // R13: set and clear of one flag in the same cycle
    new_test();
    mon_stop = 1'b1; flag_clr = 6'h10;
    @(negedge clk);
    mon_stop = 1'b0; flag_clr = 6'h00;
    chk(flags == 6'h10, "R13", "set wins over clear", flags, 6'h10);
    mon_sevt = 1'b1; @(negedge clk); mon_sevt = 1'b0;
    chk(flags == 6'h30, "R13", "slave event flag", flags, 6'h30);
    flag_clr = 6'h10; @(negedge clk); flag_clr = 6'h00;
    chk(flags == 6'h20, "R13", "single flag cleared", flags, 6'h20);
    repeat (3) @(negedge clk);
    chk(flags == 6'h20, "R13", "flag stays set", flags, 6'h20);

    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule